// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer

This block is a 16-bit down-counter that raises a periodic interrupt toward a host. A prescaler divides the system clock into a fixed timebase tick (100 microseconds by default). Each tick moves the counter down by one. When the counter is at zero, the next tick sends it to 0xFFFF rather than back to the programmed preload value. That wrap can latch a sticky status bit, which drives the interrupt line.

Software reaches the block through a small word-wide register port. The port has a configuration word with a run bit and an interrupt-enable bit, a preload word, a read-only count word and a status word whose bit is cleared by writing 1. Turning the timer on copies the preload into the counter. Writing a new preload while the timer runs restarts the count at once. Turning the timer off puts 0xFFFF back into the preload and freezes the counter.

Top module: `irq_timer`

## Requirements
- R1: After reset the configuration reads 0, the preload and the count both read 0xFFFF, the status reads 0 and `irq` is low.
- R2: A configuration write that changes the run bit (bit 0) from 0 to 1 copies the preload into the count. The count then drops by one every TICK_DIV clock cycles, where TICK_DIV = CLK_HZ / 1,000,000 × TICK_US. The first decrement comes TICK_DIV cycles after the load.
- R3: A preload write (address 1, bits 15:0) while running loads the count with the written value and restarts the prescaler, so the next decrement is a full TICK_DIV cycles later. A preload write while stopped only stores the value and leaves the count unchanged.
- R4: A tick that arrives while the count is 0x0000 sets the count to 0xFFFF, and counting goes on from there.
- R5: A wrap sets the status bit (address 3, bit 0) only when the interrupt-enable bit (configuration bit 1) is 1. With the enable at 0, a wrap leaves the status at 0.
- R6: `irq` is high exactly when the status bit is 1 and the interrupt-enable bit is 1.
- R7: Writing 1 to status bit 0 clears the status. Writing 0 leaves it unchanged.
- R8: When a status clear and a wrap that sets the status fall in the same cycle, the status ends up 1.
- R9: A configuration write that changes the run bit from 1 to 0 sets the preload to 0xFFFF. While stopped, the count holds its value.
- R10: Register map on the 2-bit address: 0 is configuration (bit 0 run, bit 1 interrupt enable), 1 is preload (bits 15:0), 2 is count (bits 15:0, read-only), 3 is status (bit 0). Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The counting path is tried with every preload value from 0 to 3, each with the interrupt enable on and off. The count is sampled one cycle before and one cycle after each expected decrement, so an early or late tick, a missing prescaler restart or a wrap to the wrong value shows up at once. The enable-off cases show whether the status gate works. Further runs reload the preload in the middle of a period, land a status clear on the exact cycle of a wrap, drop the enable while the status is set, and stop and restart the timer. These runs tell apart reload priority, set-over-clear priority, interrupt gating and the preload reset on disable.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

    typedef enum logic [1:0] {
        REG_CFG    = 2'd0,
        REG_LOAD   = 2'd1,
        REG_COUNT  = 2'd2,
        REG_STATUS = 2'd3
    } reg_addr_e;

    localparam int CFG_RUN_BIT  = 0;
    localparam int CFG_IEN_BIT  = 1;
    localparam int STS_WRAP_BIT = 0;

endpackage

// File: rtl/irq_timer_prescale.sv
module irq_timer_prescale #(
    parameter int TICK_DIV = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && !clr && (st_q.pre == LAST);
        if (clr || !run) begin
            st_d.pre = '0;
        end else if (tick) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pre <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_timer_count.sv
module irq_timer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_ev,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.cnt == '0);
        if (load_ev) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            // at zero the down-count naturally rolls to all ones
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    assign cnt = st_q.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_timer_regs.sv
module irq_timer_regs
    import irq_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap,
    output logic             run,
    output logic             ien,
    output logic             sts,
    output logic [CNT_W-1:0] preload,
    output logic             load_ev,
    output logic             stop_ev,
    output logic [CNT_W-1:0] load_val,
    output logic             irq
);
    typedef struct packed {
        logic             run;
        logic             ien;
        logic [CNT_W-1:0] preload;
        logic             sts;
    } regs_t;

    regs_t st_d, st_q;

    logic cfg_wr, ld_wr, sts_wr;
    logic unused_bits;

    assign unused_bits = ^wdata[DW-1:CNT_W];

    always_comb begin
        st_d     = st_q;
        load_ev  = 1'b0;
        stop_ev  = 1'b0;
        cfg_wr   = we && (addr == REG_CFG);
        ld_wr    = we && (addr == REG_LOAD);
        sts_wr   = we && (addr == REG_STATUS);
        load_val = ld_wr ? wdata[CNT_W-1:0] : st_q.preload;

        if (cfg_wr) begin
            st_d.run = wdata[CFG_RUN_BIT];
            st_d.ien = wdata[CFG_IEN_BIT];
            if (!st_q.run && wdata[CFG_RUN_BIT]) begin
                load_ev = 1'b1;
            end
            if (st_q.run && !wdata[CFG_RUN_BIT]) begin
                stop_ev      = 1'b1;
                st_d.preload = '1;
            end
        end

        if (ld_wr) begin
            st_d.preload = wdata[CNT_W-1:0];
            if (st_q.run) begin
                load_ev = 1'b1;
            end
        end

        if (sts_wr && wdata[STS_WRAP_BIT]) begin
            st_d.sts = 1'b0;
        end
        // a fresh wrap outranks a clear in the same cycle
        if (wrap && st_q.ien) begin
            st_d.sts = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_CFG: begin
                rdata[CFG_RUN_BIT] = st_q.run;
                rdata[CFG_IEN_BIT] = st_q.ien;
            end
            REG_LOAD:   rdata[CNT_W-1:0]    = st_q.preload;
            REG_COUNT:  rdata[CNT_W-1:0]    = cnt;
            REG_STATUS: rdata[STS_WRAP_BIT] = st_q.sts;
            default:    rdata = '0;
        endcase
    end

    assign run     = st_q.run;
    assign ien     = st_q.ien;
    assign sts     = st_q.sts;
    assign preload = st_q.preload;
    assign irq     = st_q.sts & st_q.ien;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.run     <= 1'b0;
            st_q.ien     <= 1'b0;
            st_q.preload <= '1;
            st_q.sts     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_timer.sv
module irq_timer #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_US = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int CNT_W    = 16;
    localparam int DW       = 32;
    localparam int RAW_DIV  = (CLK_HZ / 1_000_000) * TICK_US;
    localparam int TICK_DIV = (RAW_DIV < 1) ? 1 : RAW_DIV;

    logic             tick_w;
    logic             load_ev_w;
    logic             stop_ev_w;
    logic             wrap_w;
    logic             run_w;
    logic             ien_w;
    logic             sts_w;
    logic [CNT_W-1:0] preload_w;
    logic [CNT_W-1:0] load_val_w;
    logic [CNT_W-1:0] cnt_w;

    irq_timer_prescale #(
        .TICK_DIV (TICK_DIV)
    ) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .clr   (load_ev_w | stop_ev_w),
        .tick  (tick_w)
    );

    irq_timer_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .load_ev  (load_ev_w),
        .load_val (load_val_w),
        .cnt      (cnt_w),
        .wrap     (wrap_w)
    );

    irq_timer_regs #(
        .CNT_W (CNT_W),
        .DW    (DW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cnt      (cnt_w),
        .wrap     (wrap_w),
        .run      (run_w),
        .ien      (ien_w),
        .sts      (sts_w),
        .preload  (preload_w),
        .load_ev  (load_ev_w),
        .stop_ev  (stop_ev_w),
        .load_val (load_val_w),
        .irq      (irq)
    );

endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk #(
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 5000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             we,
    input logic [1:0]       addr,
    input logic [31:0]      wdata,
    input logic             tick,
    input logic             load_ev,
    input logic             run,
    input logic             ien,
    input logic             sts,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] preload
);
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1)); // R2

    AST_WRAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0) |=> cnt == '1); // R4

    AST_RESTART_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (TICK_DIV > 1 && load_ev) |=> !tick); // R3

    AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && ien) |=> sts); // R8

    AST_STS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts && !(tick && cnt == '0 && ien)) |=> !sts); // R5

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && !(we && addr == 2'd3 && wdata[0])) |=> sts); // R7

    AST_STOP_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> preload == '1); // R9

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !we) |=> $stable(cnt)); // R9

endmodule

bind irq_timer irq_timer_chk #(
    .CNT_W    (CNT_W),
    .TICK_DIV (TICK_DIV)
) u_irq_timer_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .tick    (tick_w),
    .load_ev (load_ev_w),
    .run     (run_w),
    .ien     (ien_w),
    .sts     (sts_w),
    .cnt     (cnt_w),
    .preload (preload_w)
);

// File: tb/irq_timer_bench.sv
module irq_timer_bench;
    localparam int DIV = 4;   // 4 MHz nominal clock, 1 us tick -> 4 cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    irq_timer #(.CLK_HZ(4_000_000), .TICK_US(1)) u_irq_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a);
        reg_addr = a;
        #1;
        rv = reg_rdata;
    endtask

    function automatic logic [31:0] expc(input int l, input int k);
        if (k <= l) return 32'(l - k);
        return 32'(16'hFFFF - (k - l - 1));
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        adv(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(0); check("R1 cfg", rv, 32'h0);
        rd(1); check("R1 preload", rv, 32'hFFFF);
        rd(2); check("R1 count", rv, 32'hFFFF);
        rd(3); check("R1 status", rv, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // sweep of preload and interrupt enable
        for (int ie = 0; ie < 2; ie++) begin
            for (int l = 0; l < 4; l++) begin
                rd(2); held = rv;
                wr(1, 32'(l));
                rd(2); check("R3 stopped write keeps count", rv, held);
                rd(1); check("R10 preload readback", rv, 32'(l));
                wr(0, 32'((ie << 1) | 1));
                rd(0); check("R10 cfg readback", rv, 32'((ie << 1) | 1));
                rd(2); check("R2 load on enable", rv, 32'(l));
                for (int k = 1; k <= l + 2; k++) begin
                    adv(DIV - 1);
                    rd(2); check("R2 full period", rv, expc(l, k - 1));
                    if (k == l + 1) begin
                        rd(3); check("R5 no status before wrap", rv, 32'h0);
                    end
                    adv(1);
                    rd(2); check((k == l + 1) ? "R4 wrap to FFFF" : "R2 decrement", rv, expc(l, k));
                end
                rd(3); check("R5 status gated by enable", rv, 32'(ie));
                check("R6 irq", {31'b0, irq}, 32'(ie));
                wr(3, 0);
                rd(3); check("R7 write 0 ignored", rv, 32'(ie));
                wr(3, 1);
                rd(3); check("R7 write 1 clears", rv, 32'h0);
                check("R6 irq after clear", {31'b0, irq}, 32'h0);
                wr(0, 0);
                rd(1); check("R9 preload reset on stop", rv, 32'hFFFF);
                rd(2); held = rv;
                adv(3 * DIV);
                rd(2); check("R9 count holds while stopped", rv, held);
            end
        end

        // R3 reload mid-period while running
        wr(1, 10);
        wr(0, 3);
        adv(DIV + 2);
        rd(2); check("R2 one tick", rv, 32'd9);
        wr(1, 20);
        rd(2); check("R3 reload on write", rv, 32'd20);
        adv(DIV - 1);
        rd(2); check("R3 prescaler restarted", rv, 32'd20);
        adv(1);
        rd(2); check("R3 first decrement", rv, 32'd19);

        // R8 clear lands on the wrap cycle
        wr(1, 0);
        adv(DIV - 1);
        wr(3, 1);
        rd(3); check("R8 set wins over clear", rv, 32'h1);
        rd(2); check("R4 wrap after reload", rv, 32'hFFFF);
        check("R6 irq set", {31'b0, irq}, 32'h1);
        wr(0, 1);
        rd(3); check("R6 status kept", rv, 32'h1);
        check("R6 irq masked", {31'b0, irq}, 32'h0);
        wr(0, 3);
        check("R6 irq unmasked", {31'b0, irq}, 32'h1);
        wr(3, 1);
        rd(3); check("R7 clear", rv, 32'h0);

        // R9 stop then restart loads the reset preload
        wr(1, 7);
        wr(0, 0);
        rd(1); check("R9 preload reset", rv, 32'hFFFF);
        wr(0, 1);
        rd(2); check("R9 restart loads FFFF", rv, 32'hFFFF);

        finish_run();
    end

endmodule